// File: doc/BRIEF.md
# Pulse Train Group Controller

This block sequences a bank of pulse train channels from one place. One prescaler, shared by all channels, divides the system clock by a power of two and gives every channel the same tick. The prescaler runs only while some channel is running or is waiting to relaunch. Software commands arrive on a simple write port. Most commands carry a channel bitmask in which bit n stands for channel n. They start, stop or resynchronise any subset of channels. The block drives one-cycle start and stop strobes to the channel datapaths, which are outside this block.

Each channel owns two restart slots. A slot names a source channel. When the source reports a loop exit, the owning channel is relaunched without any software action. A resync command stops the selected channels and holds them until the next prescaler tick. On that tick they all launch together, and the other channels keep running. Per-channel stop and ready flags record done and loop-exit events. They are masked by enables and merged into one interrupt request.

Top module: `pt_group_ctrl`

## Requirements
- R1: A write to address 0 with code c in data[2:0] selects the divider. While the prescaler runs, `tick_o` is high one cycle in every 2^c cycles. After a start that enables it from idle, the first tick comes 2^c-1 cycles after the strobe cycle.
- R2: When no channel is active and no resync launch is pending, `tick_o` stays low.
- R3: A write to address 1 (start) with mask m raises `start_o` = m for one cycle after the write, and those channels show in `active_o`.
- R4: A write to address 2 (stop) with mask m raises `stop_o` = m for one cycle after the write and clears those bits of `active_o`.
- R5: A write to address 10 configures a restart slot. The fields are owner in data[7:0], source in data[15:8], slot index in data[16] and enable in data[24]. A loop exit of the source then raises `start_o` for the owner in the next cycle, if the slot is enabled. A disabled slot has no effect.
- R6: When a restart trigger and a stop command hit the same channel in one cycle, the channel gets a stop strobe, gets no start strobe, and ends inactive.
- R7: A write to address 3 (resync) with mask m strobes `stop_o` = m and clears those active bits. The selected channels then all strobe `start_o` together in the cycle after the next tick. Unselected channels see no strobe and stay active.
- R8: `done_i[n]` clears channel n from `active_o` and sets stop flag n. `loop_exit_i[n]` sets ready flag n.
- R9: The enable writes take a mask in which a 1 acts on that channel and a 0 leaves it unchanged. Address 4 sets stop enables, 5 clears them, 6 sets ready enables and 7 clears them.
- R10: Writing 1s to address 8 clears those stop flags. Writing 1s to address 9 clears those ready flags. Bits written 0 are kept.
- R11: `irq_o` is high exactly when some flag is set while its enable is set.
- R12: `query_any_o` is high when any channel selected by `query_mask_i` is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | DATA_W | Write data |
| loop_exit_i | input | NCH | Per-channel loop exit event |
| done_i | input | NCH | Per-channel done event |
| query_mask_i | input | NCH | Channels to test for activity |
| start_o | output | NCH | Per-channel start strobe |
| stop_o | output | NCH | Per-channel stop strobe |
| tick_o | output | 1 | Shared prescaler tick |
| active_o | output | NCH | Running status per channel |
| query_any_o | output | 1 | Some queried channel is active |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions take for granted that loop-exit and done events are single-cycle pulses, and that a command write and an event on the same channel appear together only where a priority rule says who wins. The stop-versus-restart collision is one such case. The directed part of the stimulus creates that collision on purpose and otherwise keeps writes and events apart. The random phase draws one operation per step, either a write or an event mask, so a flag never sees a set and a clear in the same cycle.

// File: rtl/pt_grp_pkg.sv
package pt_grp_pkg;
  typedef enum logic [3:0] {
    A_SCALE   = 4'd0,
    A_START   = 4'd1,
    A_STOP    = 4'd2,
    A_RESYNC  = 4'd3,
    A_SIE_SET = 4'd4,
    A_SIE_CLR = 4'd5,
    A_RIE_SET = 4'd6,
    A_RIE_CLR = 4'd7,
    A_SFL_CLR = 4'd8,
    A_RFL_CLR = 4'd9,
    A_RESTART = 4'd10
  } pt_addr_e;

  // restart slot write fields
  localparam int unsigned RS_OWNER_LSB = 0;
  localparam int unsigned RS_SRC_LSB   = 8;
  localparam int unsigned RS_SLOT_BIT  = 16;
  localparam int unsigned RS_EN_BIT    = 24;
endpackage

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int unsigned SCALE_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               code_we_i,
  input  logic [SCALE_W-1:0] code_i,
  output logic               tick_o
);
  localparam int unsigned CNT_W = (1 << SCALE_W) - 1;

  logic [SCALE_W-1:0] code_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   lim;

  assign lim    = ~({CNT_W{1'b1}} << code_q);
  assign tick_o = en_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (code_we_i) code_q <= code_i;
      if (!en_i || code_we_i) cnt_q <= '0;
      else if (cnt_q == lim)  cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pt_restart_mux.sv
module pt_restart_mux #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_owner_i,
  input  logic [IDX_W-1:0] cfg_src_i,
  input  logic             cfg_slot_i,
  input  logic             cfg_en_i,
  input  logic [NCH-1:0]   loop_exit_i,
  output logic [NCH-1:0]   trig_o
);
  localparam int unsigned NSLOT = 2;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [NSLOT-1:0] hit;
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [IDX_W-1:0] src_q;
      logic             en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          src_q <= '0;
          en_q  <= 1'b0;
        end else if (cfg_we_i && (32'(cfg_owner_i) == ch) && (32'(cfg_slot_i) == s)) begin
          src_q <= cfg_src_i;
          en_q  <= cfg_en_i;
        end
      end
      assign hit[s] = en_q && (32'(src_q) < NCH) && loop_exit_i[src_q];
    end
    assign trig_o[ch] = |hit;
  end
endmodule

// File: rtl/pt_irq_regs.sv
module pt_irq_regs #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] mask_i,
  input  logic           sie_set_i,
  input  logic           sie_clr_i,
  input  logic           rie_set_i,
  input  logic           rie_clr_i,
  input  logic           sfl_clr_i,
  input  logic           rfl_clr_i,
  input  logic [NCH-1:0] stop_ev_i,
  input  logic [NCH-1:0] rdy_ev_i,
  output logic [NCH-1:0] stop_fl_o,
  output logic [NCH-1:0] rdy_fl_o,
  output logic           irq_o
);
  logic [NCH-1:0] sie_q, rie_q, sfl_q, rfl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sie_q <= '0;
      rie_q <= '0;
      sfl_q <= '0;
      rfl_q <= '0;
    end else begin
      if (sie_set_i) sie_q <= sie_q | mask_i;
      if (sie_clr_i) sie_q <= sie_q & ~mask_i;
      if (rie_set_i) rie_q <= rie_q | mask_i;
      if (rie_clr_i) rie_q <= rie_q & ~mask_i;
      // event set wins over clear
      sfl_q <= (sfl_q & ~(sfl_clr_i ? mask_i : '0)) | stop_ev_i;
      rfl_q <= (rfl_q & ~(rfl_clr_i ? mask_i : '0)) | rdy_ev_i;
    end
  end

  assign stop_fl_o = sfl_q;
  assign rdy_fl_o  = rfl_q;
  assign irq_o     = |((sfl_q & sie_q) | (rfl_q & rie_q));
endmodule

// File: rtl/pt_group_ctrl.sv
module pt_group_ctrl
  import pt_grp_pkg::*;
#(
  parameter int unsigned NCH     = 8,
  parameter int unsigned SCALE_W = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [NCH-1:0]    loop_exit_i,
  input  logic [NCH-1:0]    done_i,
  input  logic [NCH-1:0]    query_mask_i,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    stop_o,
  output logic              tick_o,
  output logic [NCH-1:0]    active_o,
  output logic              query_any_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] mask;
  logic           we_scale, we_start, we_stop, we_rsync, we_rs;
  logic [NCH-1:0] cmd_start, cmd_stop, cmd_rsync;
  logic [NCH-1:0] trig, launch, start_req, stop_req;
  logic [NCH-1:0] active_q, pend_q, start_q, stop_q;
  logic [NCH-1:0] stop_fl, rdy_fl;
  logic           tick, ps_en;
  logic           unused_bits;

  assign mask     = wr_data_i[NCH-1:0];
  assign we_scale = wr_en_i && (wr_addr_i == A_SCALE);
  assign we_start = wr_en_i && (wr_addr_i == A_START);
  assign we_stop  = wr_en_i && (wr_addr_i == A_STOP);
  assign we_rsync = wr_en_i && (wr_addr_i == A_RESYNC);
  assign we_rs    = wr_en_i && (wr_addr_i == A_RESTART);
  assign unused_bits = ^wr_data_i;

  assign cmd_start = we_start ? mask : '0;
  assign cmd_stop  = we_stop  ? mask : '0;
  assign cmd_rsync = we_rsync ? mask : '0;

  assign ps_en = |{active_q, pend_q};

  pt_prescaler #(.SCALE_W(SCALE_W)) u_ps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (ps_en),
    .code_we_i (we_scale),
    .code_i    (wr_data_i[SCALE_W-1:0]),
    .tick_o    (tick)
  );

  pt_restart_mux #(.NCH(NCH), .IDX_W(IDX_W)) u_rs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (we_rs),
    .cfg_owner_i (wr_data_i[RS_OWNER_LSB +: IDX_W]),
    .cfg_src_i   (wr_data_i[RS_SRC_LSB +: IDX_W]),
    .cfg_slot_i  (wr_data_i[RS_SLOT_BIT]),
    .cfg_en_i    (wr_data_i[RS_EN_BIT]),
    .loop_exit_i (loop_exit_i),
    .trig_o      (trig)
  );

  // pending resync channels launch together on a tick
  assign launch    = tick ? pend_q : '0;
  assign stop_req  = cmd_stop | cmd_rsync;
  assign start_req = (cmd_start | trig | launch) & ~stop_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      pend_q   <= '0;
      start_q  <= '0;
      stop_q   <= '0;
    end else begin
      active_q <= (active_q & ~done_i & ~stop_req) | start_req;
      pend_q   <= (pend_q & ~start_req & ~cmd_stop) | cmd_rsync;
      start_q  <= start_req;
      stop_q   <= stop_req;
    end
  end

  pt_irq_regs #(.NCH(NCH)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_i    (mask),
    .sie_set_i (wr_en_i && (wr_addr_i == A_SIE_SET)),
    .sie_clr_i (wr_en_i && (wr_addr_i == A_SIE_CLR)),
    .rie_set_i (wr_en_i && (wr_addr_i == A_RIE_SET)),
    .rie_clr_i (wr_en_i && (wr_addr_i == A_RIE_CLR)),
    .sfl_clr_i (wr_en_i && (wr_addr_i == A_SFL_CLR)),
    .rfl_clr_i (wr_en_i && (wr_addr_i == A_RFL_CLR)),
    .stop_ev_i (done_i),
    .rdy_ev_i  (loop_exit_i),
    .stop_fl_o (stop_fl),
    .rdy_fl_o  (rdy_fl),
    .irq_o     (irq_o)
  );

  assign start_o     = start_q;
  assign stop_o      = stop_q;
  assign tick_o      = tick;
  assign active_o    = active_q;
  assign query_any_o = |(active_q & query_mask_i);
endmodule

// File: rtl/pt_group_ctrl_chk.sv
module pt_group_ctrl_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] stop_o,
  input logic [NCH-1:0] active_o,
  input logic [NCH-1:0] pend_q,
  input logic [NCH-1:0] stop_fl,
  input logic [NCH-1:0] rdy_fl,
  input logic           tick_o,
  input logic           query_any_o,
  input logic           irq_o
);
  // R3
  start_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o & ~active_o) == '0);
  // R4
  stop_inactive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o & active_o) == '0);
  // R6
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o & stop_o) == '0);
  // R2
  tick_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (|{active_o, pend_q}));
  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|{stop_fl, rdy_fl}));
  // R12
  query_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    query_any_o |-> (|active_o));
  // R7
  pend_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & active_o) == '0);
endmodule

bind pt_group_ctrl pt_group_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_o     (start_o),
  .stop_o      (stop_o),
  .active_o    (active_o),
  .pend_q      (pend_q),
  .stop_fl     (stop_fl),
  .rdy_fl      (rdy_fl),
  .tick_o      (tick_o),
  .query_any_o (query_any_o),
  .irq_o       (irq_o)
);

// File: tb/sim_pt_group_ctrl.sv
`timescale 1ns/1ps
module sim_pt_group_ctrl;
  localparam int NCH = 8;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic           wr_en_i = 1'b0;
  logic [3:0]     wr_addr_i = '0;
  logic [31:0]    wr_data_i = '0;
  logic [NCH-1:0] loop_exit_i = '0;
  logic [NCH-1:0] done_i = '0;
  logic [NCH-1:0] query_mask_i = '0;
  logic [NCH-1:0] start_o, stop_o, active_o;
  logic           tick_o, query_any_o, irq_o;

  int nchk = 0;
  int nerr = 0;

  always #4 clk_i = ~clk_i;

  pt_group_ctrl u0 (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .loop_exit_i,
    .done_i, .query_mask_i, .start_o, .stop_o, .tick_o, .active_o,
    .query_any_o, .irq_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic ev(input logic [NCH-1:0] lx, input logic [NCH-1:0] dn);
    loop_exit_i = lx; done_i = dn;
    step();
    loop_exit_i = '0; done_i = '0;
  endtask

  function automatic logic [31:0] rs_cfg(int owner, int src, int slot, int en);
    return (32'(en) << 24) | (32'(slot) << 16) | (32'(src) << 8) | 32'(owner);
  endfunction

  function automatic logic exp_irq(logic [NCH-1:0] sf, logic [NCH-1:0] se,
                                   logic [NCH-1:0] rf, logic [NCH-1:0] re);
    return |((sf & se) | (rf & re));
  endfunction

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int cnt;
    logic t;
    logic seen;
    logic [NCH-1:0] sf, se, rf, re, m;
    void'($urandom(32'd1234));
    query_mask_i = 8'hFF;
    #19 rst_ni = 1'b1;
    #1;
    chk("reset start_o", 32'(start_o), 0);
    chk("reset stop_o", 32'(stop_o), 0);
    chk("reset active_o", 32'(active_o), 0);
    chk("reset irq_o", 32'(irq_o), 0);
    chk("R12 reset query", 32'(query_any_o), 0);

    cnt = 0;
    for (int i = 0; i < 8; i++) begin cnt += int'(tick_o); step(); end
    chk("R2 idle ticks", cnt, 0);

    wr(4'd0, 32'd2);
    wr(4'd1, 32'h01);
    chk("R3 start strobe", 32'(start_o), 32'h01);
    chk("R3 active", 32'(active_o), 32'h01);
    cnt = 0;
    for (int i = 0; i < 16; i++) begin
      if (tick_o) begin
        cnt++;
        if (i % 4 != 3) chk("R1 tick phase", i, 3);
      end
      step();
    end
    chk("R1 tick count div4", cnt, 4);
    chk("R3 strobe one cycle", 32'(start_o), 0);

    wr(4'd10, rs_cfg(1, 0, 0, 1));
    wr(4'd10, rs_cfg(2, 0, 1, 0));
    wr(4'd10, rs_cfg(3, 2, 1, 1));
    ev(8'h01, 8'h00);
    chk("R5 slot0 restart, disabled slot ignored", 32'(start_o), 32'h02);
    chk("R5 active", 32'(active_o), 32'h03);

    query_mask_i = 8'h04; #1;
    chk("R12 query inactive", 32'(query_any_o), 0);
    query_mask_i = 8'h02; #1;
    chk("R12 query active", 32'(query_any_o), 1);
    query_mask_i = 8'hFF;

    wr(4'd1, 32'h04);
    ev(8'h04, 8'h00);
    chk("R5 slot1 restart", 32'(start_o), 32'h08);
    chk("R5 active all", 32'(active_o), 32'h0F);

    loop_exit_i = 8'h01;
    wr(4'd2, 32'h02);
    loop_exit_i = '0;
    chk("R6 no start", 32'(start_o), 0);
    chk("R6 stop strobe", 32'(stop_o), 32'h02);
    chk("R6 inactive", 32'(active_o), 32'h0D);
    wr(4'd1, 32'h02);

    wr(4'd3, 32'h03);
    chk("R7 resync stop strobe", 32'(stop_o), 32'h03);
    chk("R7 others run", 32'(active_o), 32'h0C);
    seen = 1'b0;
    for (int i = 0; i < 10 && !seen; i++) begin
      t = tick_o;
      step();
      if (start_o != 0) begin
        seen = 1'b1;
        chk("R7 lockstep start", 32'(start_o), 32'h03);
        chk("R7 launched on tick", 32'(t), 1);
        chk("R7 all active", 32'(active_o), 32'h0F);
      end else begin
        chk("R7 no stray stop", 32'(stop_o), 0);
        chk("R7 unselected active", 32'(active_o), 32'h0C);
      end
    end
    chk("R7 launch seen", 32'(seen), 1);

    wr(4'd2, 32'hFF);
    chk("R4 stop strobe", 32'(stop_o), 32'hFF);
    chk("R4 inactive", 32'(active_o), 0);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin cnt += int'(tick_o); step(); end
    chk("R2 gated after stop", cnt, 0);

    wr(4'd1, 32'h01);
    ev(8'h00, 8'h01);
    chk("R8 done clears active", 32'(active_o), 0);
    chk("R11 no enables", 32'(irq_o), 0);
    wr(4'd4, 32'h01);
    chk("R8 stop flag via irq", 32'(irq_o), 1);
    wr(4'd8, 32'h01);
    chk("R10 stop flag cleared", 32'(irq_o), 0);
    wr(4'd5, 32'h01);
    wr(4'd6, 32'h01);
    chk("R8 ready flag via irq", 32'(irq_o), 1);
    wr(4'd7, 32'h01);
    chk("R9 ready enable cleared", 32'(irq_o), 0);

    wr(4'd8, 32'hFF);
    wr(4'd9, 32'hFF);
    sf = '0; se = '0; rf = '0; re = '0;
    for (int i = 0; i < 80; i++) begin
      int op;
      op = int'($urandom % 8);
      m = NCH'($urandom);
      case (op)
        0: begin wr(4'd4, 32'(m)); se |= m;  chk("R9 stop ie set", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        1: begin wr(4'd5, 32'(m)); se &= ~m; chk("R9 stop ie clr", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        2: begin wr(4'd6, 32'(m)); re |= m;  chk("R9 ready ie set", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        3: begin wr(4'd7, 32'(m)); re &= ~m; chk("R9 ready ie clr", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        4: begin wr(4'd8, 32'(m)); sf &= ~m; chk("R10 stop fl clr", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        5: begin wr(4'd9, 32'(m)); rf &= ~m; chk("R10 ready fl clr", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        6: begin ev('0, m); sf |= m;         chk("R11 done event", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
        default: begin ev(m, '0); rf |= m;   chk("R11 loop event", 32'(irq_o), 32'(exp_irq(sf, se, rf, re))); end
      endcase
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule